// File: doc/BRIEF.md
# Scanline Event Sequencer

The sequencer follows one video line's master-cycle counter and raises a one-clock strobe each time the counter reaches the position of the next event in a fixed ring. The ring runs hblank start, line transfer start, line end, line transfer init, render, memory refresh, and then back to hblank start. The transfer and render strobes are gated by the current line number. The render strobe carries the index of the visible line. The refresh strobe comes with a stall request and a fixed stall length, which the surrounding cycle counter adds to its count.

The line-end position is derived inside the block. A line is 1364 cycles long. It is 1360 cycles long when it is line 240 of an odd field while interlace is off. On the newer silicon revision the refresh position alternates from line to line. On the older revision it stays fixed. After line end the block waits for the external counter to wrap below the line length, and only then does it look at the next event.

The state machine has seven states. ST_HBLANK, ST_XSTART, ST_LEND, ST_XINIT, ST_RENDER and ST_REFRESH each wait for their own event. ST_WRAP waits for the counter to wrap. Each state moves to the next one in that ring on the clock edge where its condition holds: the counter is at or past the pending position, or, for ST_WRAP, the counter is below the line length. ST_REFRESH returns to ST_HBLANK. Reset enters ST_XINIT.

Top module: `scan_event_seq`

## Requirements
- R1: Events fire only in the ring order hblank start, line transfer start, line end, line transfer init, render, refresh, hblank start. After line end, no event fires until the cycle counter has dropped below the line length.
- R2: An event fires in the cycle that follows the clock edge at which the counter is at or past its position. At most one strobe is high in any cycle.
- R3: The line end position is 1364. It is 1360 when line_num is 240, interlace is 0 and odd_field is 1.
- R4: With rev2=1, the refresh position is 534 after reset. Each refresh event swaps it between 534 and 538, except a refresh event on the short line of R3, which leaves it unchanged.
- R5: With rev2=0, the refresh position is 538 on every line and is not swapped.
- R6: stall_req is high in exactly the cycles where ev_refresh is high, and stall_cycles reads 40.
- R7: ev_xinit is raised only when the line transfer init event occurs with line_num equal to 0.
- R8: ev_xstart is raised only when line_num is at most vis_height.
- R9: ev_render is raised only when line_num lies between 1 and vis_height inclusive, with render_line equal to line_num minus 1.
- R10: When the counter jumps past several positions at once, the due events are handled one per clock, in ring order, until the pending position lies ahead of the counter.
- R11: After reset all strobes are low and the first pending event is line transfer init.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_pos | input | 11 | Master-cycle position within the line |
| pos_hblank | input | 11 | Hblank start position |
| pos_xstart | input | 11 | Line transfer start position |
| pos_xinit | input | 11 | Line transfer init position |
| pos_render | input | 11 | Render position |
| line_num | input | 9 | Current line number |
| vis_height | input | 9 | Last visible line |
| rev2 | input | 1 | 1 selects the newer revision |
| interlace | input | 1 | Interlace mode active |
| odd_field | input | 1 | Current frame is an odd field |
| ev_hblank | output | 1 | Hblank start strobe |
| ev_xstart | output | 1 | Line transfer start strobe |
| ev_line_end | output | 1 | Line end strobe |
| ev_xinit | output | 1 | Line transfer init strobe |
| ev_render | output | 1 | Render strobe |
| render_line | output | 9 | Visible line index that goes with ev_render |
| ev_refresh | output | 1 | Memory refresh strobe |
| stall_req | output | 1 | Refresh stall request |
| stall_cycles | output | 6 | Stall length to add to the cycle counter |

## Verification
The counter jump is the case where several events fall due in the same cycle. The bench provokes it by moving the counter from zero straight to a value beyond the init, render, refresh and hblank positions. It then judges that the four events come out on four consecutive clocks, in ring order, with one strobe per clock. A second coincidence is on line 240 of an odd non-interlaced field. There the shortened line end and the suppressed refresh toggle both fall on the same line. They are judged by the line end appearing at 1360 rather than 1364, and by the next line refreshing at the same position.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [2:0] {
        ST_HBLANK,
        ST_XSTART,
        ST_LEND,
        ST_WRAP,
        ST_XINIT,
        ST_RENDER,
        ST_REFRESH
    } seq_state_e;
endpackage

// File: rtl/seq_line_len.sv
module seq_line_len #(
    parameter int CYC_W      = 11,
    parameter int LN_W       = 9,
    parameter int LINE_LEN   = 1364,
    parameter int SHORT_LEN  = 1360,
    parameter int SHORT_LINE = 240
) (
    input  logic [LN_W-1:0]  line_num,
    input  logic             interlace,
    input  logic             odd_field,
    output logic             short_line,
    output logic [CYC_W-1:0] line_len
);
    always_comb begin
        short_line = (line_num == LN_W'(SHORT_LINE)) && !interlace && odd_field;
        line_len   = short_line ? CYC_W'(SHORT_LEN) : CYC_W'(LINE_LEN);
    end
endmodule

// File: rtl/seq_refresh_pos.sv
module seq_refresh_pos #(
    parameter int CYC_W  = 11,
    parameter int REF_A  = 534,
    parameter int REF_B  = 538,
    parameter int REF_R1 = 538
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rev2,
    input  logic             short_line,
    input  logic             refresh_step,
    output logic [CYC_W-1:0] ref_pos
);
    logic alt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            alt_q <= 1'b0;
        else if (refresh_step && rev2 && !short_line)
            alt_q <= !alt_q;
    end

    always_comb begin
        if (!rev2)
            ref_pos = CYC_W'(REF_R1);
        else
            ref_pos = alt_q ? CYC_W'(REF_B) : CYC_W'(REF_A);
    end

    // R4: a refresh on an ordinary line moves the next position
    a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_step && rev2 && !short_line) |=> (rev2 && (ref_pos != $past(ref_pos))) || !rev2);
endmodule

// File: rtl/seq_event_gate.sv
module seq_event_gate #(
    parameter int LN_W      = 9,
    parameter int VIS_FIRST = 1
) (
    input  logic [LN_W-1:0] line_num,
    input  logic [LN_W-1:0] vis_height,
    output logic            ok_xinit,
    output logic            ok_xstart,
    output logic            ok_render,
    output logic [LN_W-1:0] render_idx
);
    always_comb begin
        ok_xinit   = (line_num == '0);
        ok_xstart  = (line_num <= vis_height);
        ok_render  = (line_num >= LN_W'(VIS_FIRST)) && (line_num <= vis_height);
        render_idx = line_num - LN_W'(VIS_FIRST);
    end
endmodule

// File: rtl/scan_event_seq.sv
module scan_event_seq
    import seq_pkg::*;
#(
    parameter int CYC_W      = 11,
    parameter int LN_W       = 9,
    parameter int STALL_W    = 6,
    parameter int STALL_LEN  = 40,
    parameter int LINE_LEN   = 1364,
    parameter int SHORT_LEN  = 1360,
    parameter int SHORT_LINE = 240,
    parameter int REF_A      = 534,
    parameter int REF_B      = 538,
    parameter int REF_R1     = 538,
    parameter int VIS_FIRST  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CYC_W-1:0]   cycle_pos,
    input  logic [CYC_W-1:0]   pos_hblank,
    input  logic [CYC_W-1:0]   pos_xstart,
    input  logic [CYC_W-1:0]   pos_xinit,
    input  logic [CYC_W-1:0]   pos_render,
    input  logic [LN_W-1:0]    line_num,
    input  logic [LN_W-1:0]    vis_height,
    input  logic               rev2,
    input  logic               interlace,
    input  logic               odd_field,
    output logic               ev_hblank,
    output logic               ev_xstart,
    output logic               ev_line_end,
    output logic               ev_xinit,
    output logic               ev_render,
    output logic [LN_W-1:0]    render_line,
    output logic               ev_refresh,
    output logic               stall_req,
    output logic [STALL_W-1:0] stall_cycles
);
    seq_state_e       state_q, state_d;
    logic [CYC_W-1:0] due_pos;
    logic [CYC_W-1:0] line_len;
    logic [CYC_W-1:0] ref_pos;
    logic             short_line;
    logic             fire;
    logic             ok_xinit, ok_xstart, ok_render;
    logic [LN_W-1:0]  render_idx;

    seq_line_len #(
        .CYC_W(CYC_W), .LN_W(LN_W), .LINE_LEN(LINE_LEN),
        .SHORT_LEN(SHORT_LEN), .SHORT_LINE(SHORT_LINE)
    ) u_len (
        .line_num(line_num), .interlace(interlace), .odd_field(odd_field),
        .short_line(short_line), .line_len(line_len)
    );

    seq_refresh_pos #(
        .CYC_W(CYC_W), .REF_A(REF_A), .REF_B(REF_B), .REF_R1(REF_R1)
    ) u_ref (
        .clk(clk), .rst_n(rst_n), .rev2(rev2), .short_line(short_line),
        .refresh_step(fire && (state_q == ST_REFRESH)), .ref_pos(ref_pos)
    );

    seq_event_gate #(.LN_W(LN_W), .VIS_FIRST(VIS_FIRST)) u_gate (
        .line_num(line_num), .vis_height(vis_height),
        .ok_xinit(ok_xinit), .ok_xstart(ok_xstart), .ok_render(ok_render),
        .render_idx(render_idx)
    );

    // next-state selection
    always_comb begin
        due_pos = line_len;
        state_d = state_q;
        unique case (state_q)
            ST_HBLANK:  begin due_pos = pos_hblank; state_d = ST_XSTART;  end
            ST_XSTART:  begin due_pos = pos_xstart; state_d = ST_LEND;    end
            ST_LEND:    begin due_pos = line_len;   state_d = ST_WRAP;    end
            ST_WRAP:    begin due_pos = line_len;   state_d = ST_XINIT;   end
            ST_XINIT:   begin due_pos = pos_xinit;  state_d = ST_RENDER;  end
            ST_RENDER:  begin due_pos = pos_render; state_d = ST_REFRESH; end
            ST_REFRESH: begin due_pos = ref_pos;    state_d = ST_HBLANK;  end
            default:    begin due_pos = line_len;   state_d = ST_XINIT;   end
        endcase
        fire = (state_q == ST_WRAP) ? (cycle_pos < line_len) : (cycle_pos >= due_pos);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_XINIT;
        else if (fire)
            state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_hblank   <= 1'b0;
            ev_xstart   <= 1'b0;
            ev_line_end <= 1'b0;
            ev_xinit    <= 1'b0;
            ev_render   <= 1'b0;
            ev_refresh  <= 1'b0;
            stall_req   <= 1'b0;
            render_line <= '0;
        end else begin
            ev_hblank   <= fire && (state_q == ST_HBLANK);
            ev_xstart   <= fire && (state_q == ST_XSTART) && ok_xstart;
            ev_line_end <= fire && (state_q == ST_LEND);
            ev_xinit    <= fire && (state_q == ST_XINIT) && ok_xinit;
            ev_render   <= fire && (state_q == ST_RENDER) && ok_render;
            ev_refresh  <= fire && (state_q == ST_REFRESH);
            stall_req   <= fire && (state_q == ST_REFRESH);
            if (fire && (state_q == ST_RENDER))
                render_line <= render_idx;
        end
    end

    assign stall_cycles = STALL_W'(STALL_LEN);

    // R2: one strobe per cycle
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_hblank, ev_xstart, ev_line_end, ev_xinit, ev_render, ev_refresh}));
    // R1: after line end, hold while the counter has not wrapped
    a_r1_wrap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRAP && cycle_pos >= line_len) |=> state_q == ST_WRAP);
    // R3: line end only once the counter reached the line length
    a_r3_line_end: assert property (@(posedge clk) disable iff (!rst_n)
        ev_line_end |-> $past(cycle_pos) >= $past(line_len));
    // R7: init strobe only on line 0
    a_r7_xinit_line0: assert property (@(posedge clk) disable iff (!rst_n)
        ev_xinit |-> $past(line_num) == '0);
    // R6: stall request accompanies refresh
    a_r6_stall_pair: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> ev_refresh && ($past(cycle_pos) >= $past(ref_pos)));
endmodule

// File: tb/tb_scan_event_seq.sv
module tb_scan_event_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] cycle_pos = '0;
    logic [10:0] pos_hblank = 11'd1096;
    logic [10:0] pos_xstart = 11'd1106;
    logic [10:0] pos_xinit  = 11'd20;
    logic [10:0] pos_render = 11'd48;
    logic [8:0]  line_num = '0;
    logic [8:0]  vis_height = 9'd224;
    logic        rev2 = 1'b1;
    logic        interlace = 1'b0;
    logic        odd_field = 1'b0;
    logic        ev_hblank, ev_xstart, ev_line_end, ev_xinit, ev_render, ev_refresh, stall_req;
    logic [8:0]  render_line;
    logic [5:0]  stall_cycles;

    int checks = 0;
    int errors = 0;
    bit exp_alt = 1'b0;

    always #10 clk = !clk;

    scan_event_seq dut (
        .clk(clk), .rst_n(rst_n), .cycle_pos(cycle_pos),
        .pos_hblank(pos_hblank), .pos_xstart(pos_xstart),
        .pos_xinit(pos_xinit), .pos_render(pos_render),
        .line_num(line_num), .vis_height(vis_height), .rev2(rev2),
        .interlace(interlace), .odd_field(odd_field),
        .ev_hblank(ev_hblank), .ev_xstart(ev_xstart), .ev_line_end(ev_line_end),
        .ev_xinit(ev_xinit), .ev_render(ev_render), .render_line(render_line),
        .ev_refresh(ev_refresh), .stall_req(stall_req), .stall_cycles(stall_cycles)
    );

    // strobe vector: {hblank, xstart, line_end, xinit, render, refresh, stall}
    function automatic logic [6:0] strobes();
        return {ev_hblank, ev_xstart, ev_line_end, ev_xinit, ev_render, ev_refresh, stall_req};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(logic [10:0] c);
        cycle_pos = c;
        @(posedge clk);
        @(negedge clk);
    endtask

    // walk one whole line with the ring model
    task automatic run_line(int ln, bit r2, bit il, bit odd);
        bit   short_l = (ln == 240) && !il && odd;
        int   rpos = r2 ? (exp_alt ? 538 : 534) : 538;
        int   len = short_l ? 1360 : 1364;
        logic xs = (ln <= 224);
        logic rd = (ln >= 1) && (ln <= 224);
        line_num = 9'(ln); rev2 = r2; interlace = il; odd_field = odd;
        step(0);
        check("R1 wrap exit quiet", 16'(strobes()), 16'h0);
        step(20);
        check("R7 xinit gate", 16'(strobes()), {9'h0, 3'b000, (ln == 0), 3'b000});
        step(48);
        check("R9 render gate", 16'(strobes()), {9'h0, 4'b0000, rd, 2'b00});
        if (rd) check("R9 render_line", 16'(render_line), 16'(ln - 1));
        step(11'(rpos - 1));
        check("R4 R5 refresh early quiet", 16'(strobes()), 16'h0);
        step(11'(rpos));
        check("R4 R5 R6 refresh with stall", 16'(strobes()), 16'h0003);
        if (r2 && !short_l) exp_alt = !exp_alt;
        step(1096);
        check("R1 hblank", 16'(strobes()), 16'h0040);
        step(1106);
        check("R8 xstart gate", 16'(strobes()), {9'h0, 1'b0, xs, 5'b00000});
        step(11'(len - 1));
        check("R3 no early line end", 16'(strobes()), 16'h0);
        step(11'(len));
        check("R3 line end", 16'(strobes()), 16'h0010);
        step(11'(len));
        check("R1 hold before wrap", 16'(strobes()), 16'h0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R11 strobes low", 16'(strobes()), 16'h0);
        check("R6 stall length", 16'(stall_cycles), 16'd40);
        exp_alt = 1'b0;
    endtask

    task automatic test_jump();
        line_num = 9'd0; rev2 = 1'b1; interlace = 1'b0; odd_field = 1'b0;
        step(1100);
        check("R10 wrap exit", 16'(strobes()), 16'h0);
        step(1100);
        check("R10 xinit first", 16'(strobes()), 16'h0008);
        step(1100);
        check("R10 render slot gated", 16'(strobes()), 16'h0);
        step(1100);
        check("R10 refresh third", 16'(strobes()), 16'h0003);
        exp_alt = !exp_alt;
        step(1100);
        check("R10 hblank fourth", 16'(strobes()), 16'h0040);
        step(1100);
        check("R10 stop when ahead", 16'(strobes()), 16'h0);
        step(1106);
        check("R10 xstart", 16'(strobes()), 16'h0020);
        step(1364);
        check("R10 line end", 16'(strobes()), 16'h0010);
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        run_line(0, 1'b1, 1'b0, 1'b0);
        run_line(1, 1'b1, 1'b0, 1'b0);
        run_line(230, 1'b1, 1'b0, 1'b0);
        run_line(239, 1'b1, 1'b0, 1'b1);
        run_line(240, 1'b1, 1'b0, 1'b1);
        run_line(241, 1'b1, 1'b0, 1'b1);
        run_line(240, 1'b1, 1'b1, 1'b1);
        run_line(5, 1'b0, 1'b0, 1'b0);
        run_line(6, 1'b0, 1'b0, 1'b0);
        run_line(224, 1'b1, 1'b0, 1'b0);
        test_jump();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule